// File: doc/BRIEF.md
# UART Software Reset Controller

This block sits in the bus register space of a serial port and turns single bus writes into reset actions. It has three action bits. One clears the control state of the transmit FIFO. One clears the control state of the receive FIFO. The third resets the whole peripheral. The FIFO actions appear as one-cycle strobes, and each is paired with a strobe that withdraws the matching DMA request. Neither FIFO bit needs a second write to release it. A whole-peripheral reset drives two reset outputs low at once: one for the bus clock domain and one for the serial clock domain. Each output is released through a synchronizer clocked by its own domain's clock.

A small sequencer supervises the whole-peripheral reset. It has three states. `ST_IDLE` accepts register writes. A write that sets bit 0 takes it from `ST_IDLE` to `ST_HOLD`. In `ST_HOLD` the reset request stays asserted for `HOLD_CYC` bus cycles, and when the count expires the sequencer moves from `ST_HOLD` to `ST_DRAIN`. `ST_DRAIN` waits for the bus-domain reset output to go high again. Once it does, the sequencer moves from `ST_DRAIN` back to `ST_IDLE`. Register writes are discarded in `ST_HOLD` and `ST_DRAIN`, so any FIFO strobe they would have raised is dropped.

Top module: `uart_swrst_ctrl`

## Requirements
- R1: Only a write with `wr_en` high and `addr` equal to `REG_OFFS` (default 0x88) has an effect. A write to any other address does nothing, and so does `wr_en` low with matching data.
- R2: A read returns zero in all 32 bits. No action bit can be read back, and bits 31..3 are always zero.
- R3: An accepted write with bit 2 set and `fifo_present` high drives `tx_fifo_clr` and `tx_dma_clr` high for exactly the one bus cycle after the accepting edge. Bit 2 clear gives no strobe.
- R4: An accepted write with bit 1 set and `fifo_present` high drives `rx_fifo_clr` and `rx_dma_clr` high for exactly the one bus cycle after the accepting edge. Bit 1 clear gives no strobe.
- R5: While `fifo_present` is low, writes to bits 2 and 1 produce no strobe.
- R6: An accepted write with bit 0 set pulls `prst_n_out` and `srst_n_out` low right after the accepting bus edge, without waiting for an `sclk` edge. FIFO strobes requested in that same write are suppressed.
- R7: The reset request stays high for `HOLD_CYC` bus cycles. For an accepting edge E0, `prst_n_out` is low after E0 through E(HOLD_CYC+1) and high after E(HOLD_CYC+2).
- R8: `srst_n_out` is still low after edge E(HOLD_CYC). It goes high only after two `sclk` edges once the request has dropped.
- R9: Writes in `ST_HOLD` or `ST_DRAIN` are ignored. Writes are accepted again from edge E(HOLD_CYC+4).
- R10: While `presetn` is low, both reset outputs and all strobes are low. After `presetn` rises, `prst_n_out` goes high after two bus edges and `srst_n_out` goes high after two `sclk` edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus clock |
| presetn | input | 1 | Bus reset, active low, asynchronous |
| sclk | input | 1 | Serial clock |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte offset |
| wdata | input | 32 | Write data; bit 2 transmit FIFO, bit 1 receive FIFO, bit 0 whole reset |
| rdata | output | 32 | Read data, always zero |
| fifo_present | input | 1 | High when FIFOs are built in |
| tx_fifo_clr | output | 1 | Transmit FIFO control clear strobe |
| rx_fifo_clr | output | 1 | Receive FIFO control clear strobe |
| tx_dma_clr | output | 1 | Withdraw transmit DMA request strobe |
| rx_dma_clr | output | 1 | Withdraw receive DMA request strobe |
| prst_n_out | output | 1 | Bus-domain peripheral reset, active low |
| srst_n_out | output | 1 | Serial-domain peripheral reset, active low |

## Verification
Directed writes try each FIFO bit on its own, both together, and the data value zero. These separate the transmit and receive decode and show that writing zero does nothing. The same writes are repeated with `fifo_present` low, with a wrong address, and with the strobe deasserted, to show that each gate matters. Full-reset writes that also carry FIFO bits are followed by a write on every later cycle. This pins down the exact release edge in each domain, the edge at which writes are accepted again, and the suppression of FIFO strobes. A seeded random mix of addresses, data, configuration and reads, with occasional full resets, is compared against a bench model of the strobes.

// File: rtl/uart_swrst_pkg.sv
`timescale 1ns/1ps
package uart_swrst_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_HOLD  = 2'd1,
        ST_DRAIN = 2'd2
    } seq_state_e;

    // action bit positions decoded from the write data
    localparam int BIT_UR  = 0;
    localparam int BIT_RX  = 1;
    localparam int BIT_TX  = 2;
    localparam int ACT_W   = 3;
    localparam int DATA_W  = 32;
    localparam int NUM_DOM = 2;
endpackage

// File: rtl/swrst_regif.sv
`timescale 1ns/1ps
module swrst_regif
    import uart_swrst_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFFS = 'h88
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [ACT_W-1:0]  wbits,
    input  logic              fifo_present,
    input  logic              accept,
    output logic [1:0]        fifo_clr,
    output logic              full_req
);
    logic hit;

    assign hit      = wr_en && (addr == REG_OFFS) && accept;
    assign full_req = hit && wbits[BIT_UR];

    // index 0 -> receive FIFO, index 1 -> transmit FIFO
    for (genvar g = 0; g < 2; g++) begin : g_fifo
        localparam int BP = (g == 0) ? BIT_RX : BIT_TX;
        logic pulse_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pulse_q <= 1'b0;
            else
                pulse_q <= hit && fifo_present && wbits[BP] && !wbits[BIT_UR];
        end
        assign fifo_clr[g] = pulse_q;
    end
endmodule

// File: rtl/swrst_seq.sv
`timescale 1ns/1ps
module swrst_seq
    import uart_swrst_pkg::*;
#(
    parameter int HOLD_CYC = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic dom_rel,
    output logic idle,
    output logic req
);
    localparam int CNT_W = $clog2(HOLD_CYC + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_CYC - 1);

    seq_state_e st, st_nx;
    logic [CNT_W-1:0] cnt;

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:  if (start)       st_nx = ST_HOLD;
            ST_HOLD:  if (cnt == LAST) st_nx = ST_DRAIN;
            ST_DRAIN: if (dom_rel)     st_nx = ST_IDLE;
            default:                   st_nx = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st  <= ST_IDLE;
            cnt <= '0;
        end else begin
            st  <= st_nx;
            cnt <= (st == ST_HOLD) ? cnt + 1'b1 : '0;
        end
    end

    // outputs: registered request so the async reset path sees no decode glitch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            req <= 1'b0;
        else
            req <= (st_nx == ST_HOLD);
    end

    assign idle = (st == ST_IDLE);
endmodule

// File: rtl/swrst_rst_sync.sv
`timescale 1ns/1ps
module swrst_rst_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rst_n_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n)
            chain <= '0;
        else
            chain <= {chain[STAGES-2:0], 1'b1};
    end

    assign rst_n_out = chain[STAGES-1];
endmodule

// File: rtl/uart_swrst_ctrl.sv
`timescale 1ns/1ps
module uart_swrst_ctrl
    import uart_swrst_pkg::*;
#(
    parameter int ADDR_W   = 8,
    parameter logic [ADDR_W-1:0] REG_OFFS = 'h88,
    parameter int HOLD_CYC = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              sclk,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              fifo_present,
    output logic              tx_fifo_clr,
    output logic              rx_fifo_clr,
    output logic              tx_dma_clr,
    output logic              rx_dma_clr,
    output logic              prst_n_out,
    output logic              srst_n_out
);
    logic [1:0]         fifo_clr;
    logic               full_req;
    logic               fsm_idle;
    logic               req;
    logic               dom_arst_n;
    logic [NUM_DOM-1:0] dom_clk;
    logic [NUM_DOM-1:0] dom_rst_n;
    logic               unused_in;

    assign unused_in = rd_en ^ (^wdata[DATA_W-1:ACT_W]);

    swrst_regif #(.ADDR_W(ADDR_W), .REG_OFFS(REG_OFFS)) u_regif (
        .clk          (pclk),
        .rst_n        (presetn),
        .wr_en        (wr_en),
        .addr         (addr),
        .wbits        (wdata[ACT_W-1:0]),
        .fifo_present (fifo_present),
        .accept       (fsm_idle),
        .fifo_clr     (fifo_clr),
        .full_req     (full_req)
    );

    swrst_seq #(.HOLD_CYC(HOLD_CYC)) u_seq (
        .clk     (pclk),
        .rst_n   (presetn),
        .start   (full_req),
        .dom_rel (prst_n_out),
        .idle    (fsm_idle),
        .req     (req)
    );

    assign dom_arst_n = presetn && !req;
    assign dom_clk    = {sclk, pclk};

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        swrst_rst_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk       (dom_clk[d]),
            .arst_n    (dom_arst_n),
            .rst_n_out (dom_rst_n[d])
        );
    end

    assign prst_n_out  = dom_rst_n[0];
    assign srst_n_out  = dom_rst_n[1];
    assign rx_fifo_clr = fifo_clr[0];
    assign tx_fifo_clr = fifo_clr[1];
    assign rx_dma_clr  = fifo_clr[0];
    assign tx_dma_clr  = fifo_clr[1];
    assign rdata       = '0;
endmodule

// File: rtl/uart_swrst_chk.sv
`timescale 1ns/1ps
module uart_swrst_chk #(
    parameter int ADDR_W = 8,
    parameter logic [ADDR_W-1:0] REG_OFFS = 'h88
) (
    input logic              pclk,
    input logic              presetn,
    input logic              sclk,
    input logic              wr_en,
    input logic              rd_en,
    input logic [ADDR_W-1:0] addr,
    input logic [31:0]       wdata,
    input logic [31:0]       rdata,
    input logic              fifo_present,
    input logic              tx_fifo_clr,
    input logic              rx_fifo_clr,
    input logic              tx_dma_clr,
    input logic              rx_dma_clr,
    input logic              prst_n_out,
    input logic              srst_n_out,
    input logic              fsm_idle
);
    assert_read_zero_R2: assert property (@(posedge pclk) disable iff (!presetn)
        rd_en |-> (rdata == 32'h0));

    assert_tx_cause_R3: assert property (@(posedge pclk) disable iff (!presetn)
        tx_fifo_clr |-> $past(wr_en && (addr == REG_OFFS) && wdata[2]));

    assert_tx_dma_R3: assert property (@(posedge pclk) disable iff (!presetn)
        tx_dma_clr |-> $past(wr_en && (addr == REG_OFFS) && wdata[2]));

    assert_rx_cause_R4: assert property (@(posedge pclk) disable iff (!presetn)
        (rx_fifo_clr || rx_dma_clr) |-> $past(wr_en && (addr == REG_OFFS) && wdata[1]));

    assert_no_fifo_cfg_R5: assert property (@(posedge pclk) disable iff (!presetn)
        (tx_fifo_clr || rx_fifo_clr) |-> $past(fifo_present));

    assert_full_assert_R6: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && (addr == REG_OFFS) && wdata[0] && fsm_idle)
            |=> (!prst_n_out && !srst_n_out && !tx_fifo_clr && !rx_fifo_clr));

    assert_bus_release_R7: assert property (@(posedge pclk) disable iff (!presetn)
        $rose(prst_n_out) |-> $past(!prst_n_out, 2));

    assert_ser_release_R8: assert property (@(posedge sclk) disable iff (!presetn)
        $rose(srst_n_out) |-> $past(!srst_n_out, 2));

    assert_busy_ignore_R9: assert property (@(posedge pclk) disable iff (!presetn)
        (wr_en && !fsm_idle) |=> (!tx_fifo_clr && !rx_fifo_clr));
endmodule

bind uart_swrst_ctrl uart_swrst_chk #(.ADDR_W(ADDR_W), .REG_OFFS(REG_OFFS)) u_chk (
    .pclk         (pclk),
    .presetn      (presetn),
    .sclk         (sclk),
    .wr_en        (wr_en),
    .rd_en        (rd_en),
    .addr         (addr),
    .wdata        (wdata),
    .rdata        (rdata),
    .fifo_present (fifo_present),
    .tx_fifo_clr  (tx_fifo_clr),
    .rx_fifo_clr  (rx_fifo_clr),
    .tx_dma_clr   (tx_dma_clr),
    .rx_dma_clr   (rx_dma_clr),
    .prst_n_out   (prst_n_out),
    .srst_n_out   (srst_n_out),
    .fsm_idle     (fsm_idle)
);

// File: tb/uart_swrst_ctrl_tb_top.sv
`timescale 1ns/1ps
module uart_swrst_ctrl_tb_top;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] OFFS = 8'h88;
    localparam int H = 8;

    logic              pclk = 1'b0;
    logic              sclk = 1'b0;
    logic              presetn;
    logic              wr_en, rd_en, fifo_present;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata, rdata;
    logic              tx_fifo_clr, rx_fifo_clr, tx_dma_clr, rx_dma_clr;
    logic              prst_n_out, srst_n_out;
    int                checks = 0;
    int                errors = 0;

    always #10 pclk = ~pclk;
    always #17 sclk = ~sclk;

    uart_swrst_ctrl #(.ADDR_W(ADDR_W), .REG_OFFS(OFFS), .HOLD_CYC(H)) dut_i (
        .pclk(pclk), .presetn(presetn), .sclk(sclk),
        .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata), .rdata(rdata),
        .fifo_present(fifo_present),
        .tx_fifo_clr(tx_fifo_clr), .rx_fifo_clr(rx_fifo_clr),
        .tx_dma_clr(tx_dma_clr), .rx_dma_clr(rx_dma_clr),
        .prst_n_out(prst_n_out), .srst_n_out(srst_n_out)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    function automatic logic exp_strobe(input logic we, input logic [ADDR_W-1:0] a,
                                        input logic [31:0] d, input logic fp, input int b);
        return we && (a == OFFS) && fp && d[b] && !d[0];
    endfunction

    // drive at a falling edge, sample after the next rising edge
    task automatic wr_step(input logic we, input logic [ADDR_W-1:0] a, input logic [31:0] d,
                           input logic fp, input logic rd, input string req);
        logic etx, erx;
        etx = exp_strobe(we, a, d, fp, 2);
        erx = exp_strobe(we, a, d, fp, 1);
        wr_en = we; addr = a; wdata = d; fifo_present = fp; rd_en = rd;
        @(negedge pclk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk(tx_fifo_clr == etx && tx_dma_clr == etx, {req, " R3 tx strobe"},
            {30'b0, tx_dma_clr, tx_fifo_clr}, {30'b0, etx, etx});
        chk(rx_fifo_clr == erx && rx_dma_clr == erx, {req, " R4 rx strobe"},
            {30'b0, rx_dma_clr, rx_fifo_clr}, {30'b0, erx, erx});
    endtask

    // full reset sequence starting at the current falling edge (N0)
    task automatic full_seq(input logic [31:0] d);
        wr_en = 1'b1; addr = OFFS; wdata = d | 32'h1; fifo_present = 1'b1;
        @(negedge pclk);
        chk(!prst_n_out && !srst_n_out, "R6 both resets low after accept",
            {30'b0, srst_n_out, prst_n_out}, 32'h0);
        chk(!tx_fifo_clr && !rx_fifo_clr, "R6 strobes suppressed",
            {30'b0, tx_fifo_clr, rx_fifo_clr}, 32'h0);
        for (int k = 1; k <= H + 3; k++) begin
            wr_en = 1'b1; addr = OFFS; wdata = 32'h6; fifo_present = 1'b1;
            @(negedge pclk);
            chk(!tx_fifo_clr && !rx_fifo_clr, "R9 write ignored while busy",
                {30'b0, tx_fifo_clr, rx_fifo_clr}, 32'h0);
            if (k <= H + 1)
                chk(!prst_n_out, "R7 bus reset held", {31'b0, prst_n_out}, 32'h0);
            else
                chk(prst_n_out, "R7 bus reset released", {31'b0, prst_n_out}, 32'h1);
            if (k <= H)
                chk(!srst_n_out, "R8 serial reset held", {31'b0, srst_n_out}, 32'h0);
        end
        wr_en = 1'b1; addr = OFFS; wdata = 32'h4; fifo_present = 1'b1;
        @(negedge pclk);
        wr_en = 1'b0;
        chk(tx_fifo_clr && !rx_fifo_clr, "R9 write accepted again",
            {30'b0, tx_fifo_clr, rx_fifo_clr}, 32'h2);
        begin
            int n;
            n = 0;
            while (!srst_n_out && n < 12) begin
                @(negedge pclk);
                n++;
            end
            chk(srst_n_out, "R8 serial reset released", {31'b0, srst_n_out}, 32'h1);
        end
    endtask

    initial begin
        #(20 * 150000);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        presetn = 1'b0; wr_en = 1'b0; rd_en = 1'b0; addr = '0; wdata = '0; fifo_present = 1'b1;
        repeat (4) @(negedge pclk);
        chk(!prst_n_out && !srst_n_out, "R10 resets low in reset",
            {30'b0, srst_n_out, prst_n_out}, 32'h0);
        chk(!tx_fifo_clr && !rx_fifo_clr && !tx_dma_clr && !rx_dma_clr, "R10 strobes low in reset",
            {28'b0, tx_fifo_clr, rx_fifo_clr, tx_dma_clr, rx_dma_clr}, 32'h0);
        presetn = 1'b1;
        @(negedge pclk);
        chk(!prst_n_out, "R10 bus reset after one edge", {31'b0, prst_n_out}, 32'h0);
        @(negedge pclk);
        chk(prst_n_out, "R10 bus reset after two edges", {31'b0, prst_n_out}, 32'h1);
        repeat (6) @(negedge pclk);
        chk(srst_n_out, "R10 serial reset released", {31'b0, srst_n_out}, 32'h1);

        // directed corner cases
        wr_step(1'b1, OFFS, 32'h4, 1'b1, 1'b0, "tx only");
        @(negedge pclk);
        chk(!tx_fifo_clr, "R3 strobe lasts one cycle", {31'b0, tx_fifo_clr}, 32'h0);
        wr_step(1'b1, OFFS, 32'h2, 1'b1, 1'b0, "rx only");
        wr_step(1'b1, OFFS, 32'h6, 1'b1, 1'b0, "both");
        wr_step(1'b1, OFFS, 32'h0, 1'b1, 1'b0, "zero data R3 R4");
        wr_step(1'b1, OFFS, 32'h6, 1'b0, 1'b0, "no fifo R5");
        wr_step(1'b1, 8'h08, 32'h6, 1'b1, 1'b0, "wrong addr R1");
        wr_step(1'b0, OFFS, 32'h6, 1'b1, 1'b0, "no strobe R1");
        wr_step(1'b1, OFFS, 32'hFFFF_FFF8, 1'b1, 1'b1, "reserved only");
        chk(prst_n_out && srst_n_out, "R1 reserved bits no reset",
            {30'b0, srst_n_out, prst_n_out}, 32'h3);
        rd_en = 1'b1; addr = OFFS;
        #1;
        chk(rdata == 32'h0, "R2 read zero", rdata, 32'h0);
        rd_en = 1'b0;
        full_seq(32'h7);
        wr_step(1'b1, OFFS, 32'h2, 1'b1, 1'b0, "after reset");

        // seeded random traffic
        for (int i = 0; i < 400; i++) begin
            logic we, fp, rd;
            logic [ADDR_W-1:0] a;
            logic [31:0] d;
            we = ($urandom % 4) != 0;
            fp = ($urandom % 4) != 0;
            rd = $urandom % 2;
            a  = ($urandom % 2) ? OFFS : ADDR_W'($urandom);
            d  = $urandom & 32'hFFFF_FFFE;
            if (we && a == OFFS && ($urandom % 40) == 0) begin
                full_seq(d);
            end else begin
                rd_en = rd; addr = a;
                #1;
                if (rd) chk(rdata == 32'h0, "R2 random read", rdata, 32'h0);
                wr_step(we, a, d, fp, rd, "random");
            end
        end

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule